// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port behind a simple synchronous register bus. The port data register occupies a window of 256 word addresses. The word offset within that window is not a location selector. It is a per-bit mask: byte address bit n+2 enables data bit n. A write changes only the bits that the address enables. A read returns zero for every bit that the address does not enable. Software can therefore set or clear a single pin with one store, without a read-modify-write sequence.

A direction register sits in a second window, selected by the top address bit. It is written and read as a whole byte. A 1 in a bit makes that pin an output, which drives the data register bit. A 0 makes it an input. Pad inputs pass through a two-stage synchronizer. A read of the data window returns the driven value for output pins and the synchronized pad value for input pins. In both cases the read mask is applied. Read data is registered, and it holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: While rst_n is low and after its release, the data register, the direction register, pad_out, pad_oe and bus_rdata are all 0, so every pin is an input.
- R2: A write with bus_addr[10]=0 updates data bit n from bus_wdata[n] only when bus_addr[n+2] is 1. Bits with mask 0 keep their value. Writing 0xEB at byte address 0x098 changes only bits 5, 2 and 1, to 1, 0 and 1.
- R3: A read with bus_addr[10]=0 returns 0 in every bit n whose bus_addr[n+2] is 0. Reading address 0x0C4 while the port value is 0xBE returns 0x30.
- R4: bus_addr[1:0] have no effect on any access. The whole range 0x000 to 0x3FF of the data window addresses the one data register.
- R5: An access with bus_addr[10]=1 reaches the direction register as a full byte, with no masking. pad_oe equals the direction register, where 1 means output.
- R6: In a data-window read, bit n is the data register bit when direction bit n is 1, and the synchronized pad bit when direction bit n is 0.
- R7: The pad input passes through two flops. A pad value applied before rising edge k is first returned by a read captured at edge k+2.
- R8: bus_rdata is loaded on the rising edge where bus_rd is 1. It holds its value in every cycle without bus_rd, even when registers change.
- R9: pad_out always equals the data register, whatever the direction setting.
- R10: When a read and a write happen in the same cycle, the read returns the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 11 | Byte address: [10] selects the window, [9:2] is the mask, [1:0] is ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 means drive |

## Verification
The data window is exercised with masks of all-ones, all-zeros, a single bit, alternating 0x55/0xAA patterns and the two irregular example masks. Between them, these patterns show whether the mask bits line up with the correct address bits and whether bits outside the mask are left alone. Address bits [1:0] are toggled between otherwise identical accesses to show that they are ignored. With a mixed direction setting, a pad change is read on three consecutive reads. This separates the synchronizer depth, the choice of source per bit, the hold of read data and the same-cycle read-before-write ordering.

// File: rtl/gpio_mask_pkg.sv
// Shared definitions for the bit-masked GPIO port.
// Assumes the window select is the address bit just above the mask field.
package gpio_mask_pkg;
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence is implied across bits.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Shift the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Data and direction registers.
// Data writes are bit-masked; direction writes are whole-word.
// Assumes wr_en is a single-cycle qualified strobe.
module gpio_regs
    import gpio_mask_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_sel_e        sel,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);
    // Per-bit masked update of the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr_en && sel == SEL_DATA)
            data_q <= (data_q & ~mask) | (wdata & mask);
    end

    // Full-word update of the direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && sel == SEL_DIR)
            dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Combinational read path.
// Picks, per bit, the driven value or the synchronized pad value, then applies the address mask.
// Assumes pad_sync is already in the clock domain.
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  gpio_sel_e        sel,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pad_sync,
    output logic [WIDTH-1:0] rd_val
);
    logic [WIDTH-1:0] port_val;

    // Per-bit source select by direction.
    always_comb begin
        for (int i = 0; i < WIDTH; i++)
            port_val[i] = dir_q[i] ? data_q[i] : pad_sync[i];
    end

    // Window select and read masking.
    always_comb begin
        if (sel == SEL_DIR) rd_val = dir_q;
        else                rd_val = port_val & mask;
    end
endmodule

// File: rtl/gpio_mask_port.sv
// Top level of the bit-masked GPIO port.
// Byte address: [WIDTH+2] selects data/direction, [WIDTH+1:2] is the bit mask, [1:0] is ignored.
// Read data is registered and holds between reads.
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = WIDTH + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    gpio_sel_e        sel;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] rd_val;

    assign sel  = gpio_sel_e'(bus_addr[ADDR_W-1]);
    assign mask = bus_addr[WIDTH+1:2];

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .sel    (sel),
        .mask   (mask),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .sel      (sel),
        .mask     (mask),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pad_sync (pad_sync),
        .rd_val   (rd_val)
    );

    // Register read data on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_checker.sv
// Property checker for gpio_mask_port, attached by bind.
// Observes only ports of the top module.
module gpio_mask_port_checker #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = WIDTH + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe
);
    // R1: a reset cycle clears the outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

    // R2: bits outside the mask keep their value.
    a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[ADDR_W-1]) |=>
        (((pad_out ^ $past(pad_out)) & ~$past(bus_addr[WIDTH+1:2])) == '0));

    // R2: bits inside the mask take the write data.
    a_r2_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[ADDR_W-1]) |=>
        ((pad_out & $past(bus_addr[WIDTH+1:2])) ==
         ($past(bus_wdata) & $past(bus_addr[WIDTH+1:2]))));

    // R3: masked-off bits read as zero.
    a_r3_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[ADDR_W-1]) |=>
        ((bus_rdata & ~$past(bus_addr[WIDTH+1:2])) == '0));

    // R5: a direction write lands whole on pad_oe.
    a_r5_dir_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1]) |=> (pad_oe == $past(bus_wdata)));

    // R8: read data holds without a read strobe.
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: pad_out changes only through a data write.
    a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_addr[ADDR_W-1]) |=> $stable(pad_out));
endmodule

bind gpio_mask_port gpio_mask_port_checker #(.WIDTH(WIDTH)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] got;

    always #10 clk = ~clk;

    gpio_mask_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Vector: {is_write, addr[10:0], wdata, expected read}; all pins are outputs here.
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 11'h3FC, 8'h00, 8'h00},  // R2 clear all
        {1'b1, 11'h098, 8'hEB, 8'h00},  // R2 example -> 0x22
        {1'b0, 11'h3FC, 8'h00, 8'h22},  // R2
        {1'b1, 11'h3FC, 8'hBE, 8'h00},  // R2 full write
        {1'b0, 11'h0C4, 8'h00, 8'h30},  // R3 example
        {1'b1, 11'h004, 8'hFF, 8'h00},  // R2 single bit -> 0xBF
        {1'b0, 11'h3FF, 8'h00, 8'hBF},  // R4 low bits set
        {1'b1, 11'h203, 8'h00, 8'h00},  // R4 mask 0x80 -> 0x3F
        {1'b0, 11'h3FC, 8'h00, 8'h3F},  // R4
        {1'b0, 11'h000, 8'h00, 8'h00},  // R3 empty mask
        {1'b1, 11'h000, 8'hFF, 8'h00},  // R2 empty mask write
        {1'b0, 11'h3FC, 8'h00, 8'h3F},  // R2 unchanged
        {1'b1, 11'h154, 8'h00, 8'h00},  // R2 mask 0x55 -> 0x2A
        {1'b0, 11'h3FC, 8'h00, 8'h2A},  // R2
        {1'b0, 11'h2A8, 8'h00, 8'h2A}   // R3 mask 0xAA
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(11'h400, got);
        check("R1 dir after reset", got, 8'h00);

        // R5: direction register full byte, all outputs
        bus_write(11'h400, 8'hFF);
        check("R5 pad_oe", pad_oe, 8'hFF);
        bus_read(11'h400, got);
        check("R5 dir read", got, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) begin
                bus_write(VEC[i][26:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][26:16], got);
                check($sformatf("vector %0d (R2/R3/R4)", i), got, VEC[i][7:0]);
            end
        end

        // R9: pad_out follows data even when pins become inputs
        bus_write(11'h403, 8'h0F);
        check("R5 partial dir", pad_oe, 8'h0F);
        check("R9 pad_out", pad_out, 8'h2A);

        // R6: mixed direction read
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        bus_read(11'h7FC, got);
        check("R5 dir window unmasked", got, 8'h0F);
        bus_read(11'h3FC, got);
        check("R6 mixed sources", got, 8'hAA);

        // R7: two-stage sync; change pad and read back to back
        @(negedge clk);
        pad_in = 8'h5A;
        bus_addr = 11'h3FC; bus_rd = 1'b1;
        @(negedge clk);
        check("R7 edge k", bus_rdata, 8'hAA);
        @(negedge clk);
        check("R7 edge k+1", bus_rdata, 8'hAA);
        @(negedge clk);
        check("R7 edge k+2", bus_rdata, 8'h5A);
        bus_rd = 1'b0;

        // R10: read and write in the same cycle
        @(negedge clk);
        bus_addr = 11'h3FC; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R10 read-before-write", bus_rdata, 8'h5A);
        check("R9 pad_out after write", pad_out, 8'h11);

        // R8: read data holds while idle
        repeat (3) @(negedge clk);
        check("R8 rdata hold", bus_rdata, 8'h5A);
        bus_read(11'h3FC, got);
        check("R8 new read", got, 8'h51);

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset pad_out", pad_out, 8'h00);
        check("R1 re-reset pad_oe", pad_oe, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule